// File: doc/BRIEF.md
# Receive DMA Ring Writer

This block drains completed receive frames from on-chip frame storage into a circular buffer in host memory. Frame data goes out as 16-bit DMA writes. Each new frame begins on a 4-byte boundary, so a short gap is left after any frame whose length is not a multiple of four. The block keeps the write position, the offset of the newest frame and a count of frames the host has not yet been told about. Frames that failed address filtering or arrived incomplete are discarded without any write.

The host sees four registers through a small read/write port. When the host reads the frame count, the space of the frames it has just learned about becomes protected. No later frame may be written over that space until the protection is lifted. It is lifted by the next count read, by a read of the event register while its frame flag is up, or by the receive-DMA reset command. A frame that would land on protected bytes waits whole in on-chip storage. An optional interrupt pulses once per completed frame.

Top module: `rx_dma_ring`

## Requirements
- R1: A frame presented with `frm_good`=0 is consumed with a one-cycle `frm_pop` and produces no DMA write. It does not change the count, the frame offset or the write position.
- R2: Write offsets wrap modulo the buffer size. The size is 2^SMALL_AW bytes when CTRL (address 3) bit 0 is 0, and 2^LARGE_AW bytes when it is 1.
- R3: A frame of L bytes is written as ceil(L/2) words at consecutive even offsets. Each word is held until `dma_ready`. The next frame starts at the previous start plus L rounded up to a multiple of 4.
- R4: The offset register (address 1) holds the starting offset of the most recently completed frame.
- R5: Reading COUNT (address 0) returns the number of frames completed since the previous COUNT read, and the count then restarts from zero. A frame completing in the same cycle as the read is counted toward the next read.
- R6: A COUNT read that returns a nonzero value protects the bytes of the frames it reported. A frame whose padded span would touch protected bytes is neither started nor popped. No frame is started in the cycle of a COUNT read.
- R7: Protection is lifted by any of these: a later COUNT read (which protects only the newly reported frames), a read of EVENT (address 2) while its flag is set, or the receive-DMA reset.
- R8: With CTRL bit 2 clear, EVENT bit 7 rises when the count becomes nonzero and is low whenever the count is zero. Reading EVENT does not clear it.
- R9: With CTRL bit 2 set, EVENT bit 7 rises only on a `stream_end` pulse while the count is nonzero. It still clears when the count is zero.
- R10: With CTRL bit 1 set, `irq` is high for exactly the one cycle after each frame's last word is accepted. With the bit clear, `irq` stays low.
- R11: Writing CTRL with bit 6 set makes bit 6 read 1 for the next cycle, during which DMA writes are withheld. The block then returns the write position, count, frame offset, flag and all protection to zero. A frame that was in progress restarts at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | A completed frame is at the head of on-chip storage |
| frm_len | input | LEN_W | Head frame length in bytes (at least 1) |
| frm_good | input | 1 | Head frame passed filtering and was received whole |
| frm_pop | output | 1 | Head frame consumed this cycle |
| st_idx | output | LEN_W-1 | Word index read from the head frame |
| st_word | input | 16 | Word of the head frame at `st_idx` |
| dma_valid | output | 1 | DMA write request |
| dma_addr | output | LARGE_AW | Byte offset of the write from the buffer base |
| dma_data | output | 16 | Write data |
| dma_ready | input | 1 | DMA write accepted |
| stream_end | input | 1 | End of a stream transfer cycle (pulse) |
| hst_addr | input | 2 | Register select: 0 COUNT, 1 offset, 2 EVENT, 3 CTRL |
| hst_rd | input | 1 | Register read strobe |
| hst_wr | input | 1 | Register write strobe (CTRL only) |
| hst_wdata | input | 16 | Register write data |
| hst_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Frame-complete interrupt pulse |

## Verification
The bench builds the block with SMALL_AW=6, LARGE_AW=7, LEN_W=6 and CNT_W=8, which gives buffers of 64 and 128 bytes. With those sizes, a handful of frames of 3 to 30 bytes is enough to wrap the write position in both size modes. They also let a waiting frame's span cross the wrap point into protected bytes, and let the capped protected length reach the whole buffer. A behavioural model tracks protection as a per-byte map rather than as a base and length, and runs with a throttled `dma_ready` so that held words and a reset in the middle of a frame are covered.

// File: rtl/rxd_pkg.sv
// Shared definitions for the receive DMA ring writer: register selects,
// control/event bit positions and the transfer state type.
package rxd_pkg;
    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_MOVE = 1'b1
    } xfer_st_t;

    localparam logic [1:0] RA_COUNT = 2'd0;
    localparam logic [1:0] RA_SOF   = 2'd1;
    localparam logic [1:0] RA_EVENT = 2'd2;
    localparam logic [1:0] RA_CTRL  = 2'd3;

    localparam int CB_BIG    = 0;
    localparam int CB_IRQ    = 1;
    localparam int CB_STREAM = 2;
    localparam int CB_RESET  = 6;
    localparam int EB_FLAG   = 7;
endpackage

// File: rtl/rxd_regs.sv
// Host register port: holds the control bits and the self-clearing reset
// request, decodes read side effects and forms the interrupt pulse.
// Assumes single-cycle read/write strobes and that only CTRL is writable.
module rxd_regs
    import rxd_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int AW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       hst_addr,
    input  logic             hst_rd,
    input  logic             hst_wr,
    input  logic [15:0]      hst_wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic [AW-1:0]    sof,
    input  logic             flag,
    input  logic             done,
    output logic [15:0]      hst_rdata,
    output logic             cnt_rd,
    output logic             ev_rd,
    output logic             rst_pend,
    output logic             cfg_big,
    output logic             cfg_irq,
    output logic             cfg_stream,
    output logic             irq
);
    logic ctrl_wr;

    // Decode strobes that carry side effects elsewhere.
    always_comb begin
        ctrl_wr = hst_wr && (hst_addr == RA_CTRL);
        cnt_rd  = hst_rd && (hst_addr == RA_COUNT);
        ev_rd   = hst_rd && (hst_addr == RA_EVENT);
    end

    // Control bits, one-cycle reset request and registered interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_big    <= 1'b0;
            cfg_irq    <= 1'b0;
            cfg_stream <= 1'b0;
            rst_pend   <= 1'b0;
            irq        <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                cfg_big    <= hst_wdata[CB_BIG];
                cfg_irq    <= hst_wdata[CB_IRQ];
                cfg_stream <= hst_wdata[CB_STREAM];
            end
            rst_pend <= ctrl_wr && hst_wdata[CB_RESET];
            irq      <= done && cfg_irq;
        end
    end

    // Read data mux; reflects current register state.
    always_comb begin
        hst_rdata = '0;
        case (hst_addr)
            RA_COUNT: hst_rdata = 16'(cnt);
            RA_SOF:   hst_rdata = 16'(sof);
            RA_EVENT: hst_rdata[EB_FLAG] = flag;
            default: begin
                hst_rdata[CB_BIG]    = cfg_big;
                hst_rdata[CB_IRQ]    = cfg_irq;
                hst_rdata[CB_STREAM] = cfg_stream;
                hst_rdata[CB_RESET]  = rst_pend;
            end
        endcase
    end
endmodule

// File: rtl/rxd_ring.sv
// Ring bookkeeping: write position, newest frame offset, unreported frame
// count, the event flag and the protected region with its fit check.
// Assumes a frame's padded length never exceeds the selected buffer size.
module rxd_ring #(
    parameter int SMALL_AW = 14,
    parameter int LARGE_AW = 16,
    parameter int LEN_W    = 11,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_pend,
    input  logic                big,
    input  logic                stream,
    input  logic                stream_end,
    input  logic                cnt_rd,
    input  logic                ev_rd,
    input  logic                done,
    input  logic [LARGE_AW-1:0] done_base,
    input  logic [LEN_W:0]      done_pad,
    input  logic [LEN_W:0]      req_pad,
    output logic [LARGE_AW-1:0] wp,
    output logic [LARGE_AW-1:0] mask,
    output logic                fits,
    output logic [CNT_W-1:0]    cnt,
    output logic [LARGE_AW-1:0] sof,
    output logic                flag
);
    localparam int AW = LARGE_AW;
    localparam int PW = LEN_W + 1;
    localparam int CW = (PW > AW + 1) ? PW : AW + 1;

    logic [AW-1:0]    wp_q, sof_q, uns_start_q, res_base_q;
    logic [CW-1:0]    uns_bytes_q, res_len_q;
    logic             res_act_q, flag_q;
    logic [CNT_W-1:0] cnt_q, cnt_base, cnt_n;
    logic [CW-1:0]    size_b, uns_sum, pad_cap, sum_cap;
    logic [AW-1:0]    d_ahead, d_behind;
    logic             set_ev;

    // Buffer mask, distances to the protected region and running sums.
    always_comb begin
        mask     = big ? {AW{1'b1}} : AW'({SMALL_AW{1'b1}});
        size_b   = CW'(mask) + CW'(1);
        d_ahead  = (res_base_q - wp_q) & mask;
        d_behind = (wp_q - res_base_q) & mask;
        fits     = !(res_act_q && ((CW'(d_ahead) < CW'(req_pad)) ||
                                   (CW'(d_behind) < res_len_q)));
        cnt_base = cnt_rd ? '0 : cnt_q;
        cnt_n    = cnt_base + CNT_W'(done);
        uns_sum  = uns_bytes_q + CW'(done_pad);
        pad_cap  = (CW'(done_pad) > size_b) ? size_b : CW'(done_pad);
        sum_cap  = (uns_sum > size_b) ? size_b : uns_sum;
        set_ev   = stream ? stream_end : done;
    end

    // Ring state update; the receive-DMA reset clears all of it.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_pend) begin
            wp_q        <= '0;
            sof_q       <= '0;
            cnt_q       <= '0;
            flag_q      <= 1'b0;
            uns_start_q <= '0;
            uns_bytes_q <= '0;
            res_act_q   <= 1'b0;
            res_base_q  <= '0;
            res_len_q   <= '0;
        end else begin
            cnt_q <= cnt_n;
            if (done) begin
                sof_q <= done_base;
                wp_q  <= (done_base + AW'(done_pad)) & mask;
                if (cnt_base == '0) begin
                    uns_start_q <= done_base;
                    uns_bytes_q <= pad_cap;
                end else begin
                    uns_bytes_q <= sum_cap;
                end
            end else if (cnt_rd) begin
                uns_bytes_q <= '0;
            end
            if (cnt_rd) begin
                res_act_q  <= (cnt_q != '0);
                res_base_q <= uns_start_q;
                res_len_q  <= uns_bytes_q;
            end else if (ev_rd && flag_q) begin
                res_act_q <= 1'b0;
            end
            if (cnt_n == '0) flag_q <= 1'b0;
            else if (set_ev) flag_q <= 1'b1;
        end
    end

    assign wp   = wp_q;
    assign cnt  = cnt_q;
    assign sof  = sof_q;
    assign flag = flag_q;
endmodule

// File: rtl/rxd_xfer.sv
// Frame mover: drops rejected frames, starts an accepted frame only when
// it fits, and walks its words out as held DMA writes.
// Assumes the storage head (length, good bit, words) is stable until popped.
module rxd_xfer
    import rxd_pkg::*;
#(
    parameter int LARGE_AW = 16,
    parameter int LEN_W    = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_pend,
    input  logic                hold,
    input  logic                fits,
    input  logic [LARGE_AW-1:0] wp,
    input  logic [LARGE_AW-1:0] mask,
    input  logic                frm_valid,
    input  logic [LEN_W-1:0]    frm_len,
    input  logic                frm_good,
    output logic                frm_pop,
    output logic [LEN_W-2:0]    st_idx,
    input  logic [15:0]         st_word,
    output logic                dma_valid,
    output logic [LARGE_AW-1:0] dma_addr,
    output logic [15:0]         dma_data,
    input  logic                dma_ready,
    output logic [LEN_W:0]      req_pad,
    output logic                done,
    output logic [LARGE_AW-1:0] done_base,
    output logic [LEN_W:0]      done_pad
);
    localparam int AW = LARGE_AW;
    localparam int PW = LEN_W + 1;
    localparam int IW = LEN_W - 1;

    xfer_st_t      st_q;
    logic [IW-1:0] idx_q, last_q;
    logic [AW-1:0] base_q;
    logic [PW-1:0] pad_q, words;
    logic          start, drop, accept, fin;

    // Start/drop decisions, word stepping and DMA request signals.
    always_comb begin
        req_pad   = (PW'(frm_len) + PW'(3)) & ~PW'(3);
        words     = (PW'(frm_len) + PW'(1)) >> 1;
        drop      = (st_q == XS_IDLE) && frm_valid && !frm_good && !rst_pend;
        start     = (st_q == XS_IDLE) && frm_valid && frm_good && fits &&
                    !hold && !rst_pend;
        dma_valid = (st_q == XS_MOVE) && !rst_pend;
        accept    = dma_valid && dma_ready;
        fin       = accept && (idx_q == last_q);
        frm_pop   = drop || fin;
        done      = fin;
        done_base = base_q;
        done_pad  = pad_q;
        dma_addr  = (base_q + AW'({idx_q, 1'b0})) & mask;
        dma_data  = st_word;
        st_idx    = idx_q;
    end

    // Transfer state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= XS_IDLE;
            idx_q  <= '0;
            last_q <= '0;
            base_q <= '0;
            pad_q  <= '0;
        end else begin
            case (st_q)
                XS_IDLE: if (start) begin
                    st_q   <= XS_MOVE;
                    base_q <= wp;
                    pad_q  <= req_pad;
                    idx_q  <= '0;
                    last_q <= IW'(words - PW'(1));
                end
                default: begin
                    if (rst_pend || fin) st_q <= XS_IDLE;
                    else if (accept)     idx_q <= idx_q + IW'(1);
                end
            endcase
        end
    end
endmodule

// File: rtl/rx_dma_ring.sv
// Top of the receive DMA ring writer: joins the host register port, the
// ring bookkeeping and the frame mover. Buffer offsets are relative to a
// base held by the external DMA controller.
module rx_dma_ring #(
    parameter int SMALL_AW = 14,
    parameter int LARGE_AW = 16,
    parameter int LEN_W    = 11,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_valid,
    input  logic [LEN_W-1:0]    frm_len,
    input  logic                frm_good,
    output logic                frm_pop,
    output logic [LEN_W-2:0]    st_idx,
    input  logic [15:0]         st_word,
    output logic                dma_valid,
    output logic [LARGE_AW-1:0] dma_addr,
    output logic [15:0]         dma_data,
    input  logic                dma_ready,
    input  logic                stream_end,
    input  logic [1:0]          hst_addr,
    input  logic                hst_rd,
    input  logic                hst_wr,
    input  logic [15:0]         hst_wdata,
    output logic [15:0]         hst_rdata,
    output logic                irq
);
    logic                cnt_rd, ev_rd, rst_pend, cfg_big, cfg_irq, cfg_stream;
    logic                fits, flag, done;
    logic [CNT_W-1:0]    cnt;
    logic [LARGE_AW-1:0] wp, mask, sof, done_base;
    logic [LEN_W:0]      req_pad, done_pad;

    rxd_regs #(.CNT_W(CNT_W), .AW(LARGE_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_rd(hst_rd),
        .hst_wr(hst_wr), .hst_wdata(hst_wdata), .cnt(cnt), .sof(sof),
        .flag(flag), .done(done), .hst_rdata(hst_rdata), .cnt_rd(cnt_rd),
        .ev_rd(ev_rd), .rst_pend(rst_pend), .cfg_big(cfg_big),
        .cfg_irq(cfg_irq), .cfg_stream(cfg_stream), .irq(irq)
    );

    rxd_ring #(.SMALL_AW(SMALL_AW), .LARGE_AW(LARGE_AW), .LEN_W(LEN_W),
               .CNT_W(CNT_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .rst_pend(rst_pend), .big(cfg_big),
        .stream(cfg_stream), .stream_end(stream_end), .cnt_rd(cnt_rd),
        .ev_rd(ev_rd), .done(done), .done_base(done_base),
        .done_pad(done_pad), .req_pad(req_pad), .wp(wp), .mask(mask),
        .fits(fits), .cnt(cnt), .sof(sof), .flag(flag)
    );

    rxd_xfer #(.LARGE_AW(LARGE_AW), .LEN_W(LEN_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .rst_pend(rst_pend), .hold(cnt_rd),
        .fits(fits), .wp(wp), .mask(mask), .frm_valid(frm_valid),
        .frm_len(frm_len), .frm_good(frm_good), .frm_pop(frm_pop),
        .st_idx(st_idx), .st_word(st_word), .dma_valid(dma_valid),
        .dma_addr(dma_addr), .dma_data(dma_data), .dma_ready(dma_ready),
        .req_pad(req_pad), .done(done), .done_base(done_base),
        .done_pad(done_pad)
    );
endmodule

// File: rtl/rxd_chk.sv
// Property checker for the receive DMA ring writer, bound into every
// instance of the top module.
module rxd_chk #(
    parameter int SMALL_AW = 14,
    parameter int LARGE_AW = 16,
    parameter int CNT_W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dma_valid,
    input logic                dma_ready,
    input logic [LARGE_AW-1:0] dma_addr,
    input logic                frm_pop,
    input logic                frm_good,
    input logic                irq,
    input logic                hst_wr,
    input logic [1:0]          hst_addr,
    input logic [15:0]         hst_wdata,
    input logic                cfg_big,
    input logic [CNT_W-1:0]    cnt,
    input logic                flag,
    input logic [LARGE_AW-1:0] sof,
    input logic                rst_pend
);
    assert_even_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid |-> !dma_addr[0]);

    assert_small_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !cfg_big) |-> ((dma_addr >> SMALL_AW) == '0));

    assert_word_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !dma_ready && !(hst_wr && hst_addr == 2'd3 && hst_wdata[6]))
        |=> (dma_valid && $stable(dma_addr)));

    assert_drop_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_pop && !frm_good) |-> !dma_valid);

    assert_flag_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !flag);

    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_reset_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend |=> (cnt == '0 && sof == '0 && !flag && !dma_valid));
endmodule

bind rx_dma_ring rxd_chk #(.SMALL_AW(SMALL_AW), .LARGE_AW(LARGE_AW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dma_valid(dma_valid), .dma_ready(dma_ready),
    .dma_addr(dma_addr), .frm_pop(frm_pop), .frm_good(frm_good), .irq(irq),
    .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .cfg_big(cfg_big), .cnt(cnt), .flag(flag), .sof(sof), .rst_pend(rst_pend)
);

// File: tb/rx_dma_ring_bench.sv
`timescale 1ns/100ps
module rx_dma_ring_bench;
    localparam int SAW = 6, LAW = 7, LW = 6, CW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frm_valid = 1'b0, frm_good = 1'b0, frm_pop;
    logic [LW-1:0] frm_len = '0;
    logic [LW-2:0] st_idx;
    logic [15:0] st_word;
    logic dma_valid, dma_ready = 1'b1;
    logic [LAW-1:0] dma_addr;
    logic [15:0] dma_data;
    logic stream_end = 1'b0;
    logic [1:0] hst_addr = 2'd0;
    logic hst_rd = 1'b0, hst_wr = 1'b0;
    logic [15:0] hst_wdata = '0, hst_rdata;
    logic irq;
    logic [7:0] cur_id = '0;

    always #2.5 clk = ~clk;
    assign st_word = {cur_id, 8'(st_idx)};

    rx_dma_ring #(.SMALL_AW(SAW), .LARGE_AW(LAW), .LEN_W(LW), .CNT_W(CW)) u_rx_dma_ring (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
        .frm_good(frm_good), .frm_pop(frm_pop), .st_idx(st_idx),
        .st_word(st_word), .dma_valid(dma_valid), .dma_addr(dma_addr),
        .dma_data(dma_data), .dma_ready(dma_ready), .stream_end(stream_end),
        .hst_addr(hst_addr), .hst_rd(hst_rd), .hst_wr(hst_wr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq)
    );

    int checks = 0, failures = 0, cyc = 0, next_id = 1;
    bit finished = 0, slow = 0;
    int q_len[$], q_good[$], q_id[$];
    int un_start[$], un_pad[$];
    bit resmap [0:127];
    int m_wp, m_cnt, m_sof, m_flag, m_busy, m_idx, m_base, m_pad, m_words;
    int m_big, m_irqen, m_stream, m_rstp, m_irq;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic refresh_src();
        frm_valid = (q_len.size() > 0);
        frm_len   = frm_valid ? LW'(q_len[0]) : '0;
        frm_good  = frm_valid ? (q_good[0] != 0) : 1'b0;
        cur_id    = frm_valid ? 8'(q_id[0]) : 8'd0;
    endtask

    task automatic push(int len, int good);
        q_len.push_back(len); q_good.push_back(good); q_id.push_back(next_id);
        next_id++;
        refresh_src();
    endtask

    task automatic model_clear();
        m_wp = 0; m_cnt = 0; m_sof = 0; m_flag = 0; m_busy = 0; m_idx = 0;
        foreach (resmap[i]) resmap[i] = 0;
        un_start.delete(); un_pad.delete();
    endtask

    // One clock: predict, compare, advance the model. Entered at a negedge.
    task automatic step();
        int mask, pad, e_rd, sum;
        bit fit, drop, start, exp_valid, accept, done, cnt_rd, ev_rd, new_rstp;
        if (slow) dma_ready = (cyc % 3) != 2;
        #1;
        mask = m_big ? 127 : 63;
        pad  = (int'(frm_len) + 3) & ~3;
        fit = 1;
        for (int k = 0; k < pad; k++) if (resmap[(m_wp + k) & mask]) fit = 0;
        cnt_rd = hst_rd && hst_addr == 2'd0;
        ev_rd  = hst_rd && hst_addr == 2'd2;
        drop   = !m_busy && frm_valid && !frm_good && !m_rstp;
        start  = !m_busy && frm_valid && frm_good && fit && !cnt_rd && !m_rstp;
        exp_valid = m_busy && !m_rstp;
        accept = exp_valid && dma_ready;
        done   = accept && (m_idx == m_words - 1);
        chk("R3 valid", int'(dma_valid), int'(exp_valid));
        if (exp_valid) begin
            chk("R2 addr", int'(dma_addr), (m_base + 2 * m_idx) & mask);
            chk("R3 data", int'(dma_data), (int'(cur_id) << 8) | m_idx);
        end
        chk("R1 pop", int'(frm_pop), int'(drop || done));
        chk("R10 irq", int'(irq), m_irq);
        case (hst_addr)
            2'd0: begin e_rd = m_cnt; chk("R5 count", int'(hst_rdata), e_rd); end
            2'd1: begin e_rd = m_sof; chk("R4 offset", int'(hst_rdata), e_rd); end
            2'd2: begin e_rd = m_flag << 7; chk("R8 event", int'(hst_rdata), e_rd); end
            default: begin
                e_rd = (m_rstp << 6) | (m_stream << 2) | (m_irqen << 1) | m_big;
                chk("R11 ctrl", int'(hst_rdata), e_rd);
            end
        endcase
        new_rstp = hst_wr && hst_addr == 2'd3 && hst_wdata[6];
        @(posedge clk);
        cyc++;
        m_irq = int'(done) & m_irqen;
        if (m_rstp) begin
            model_clear();
        end else begin
            if (cnt_rd) begin
                foreach (resmap[i]) resmap[i] = 0;
                if (m_cnt != 0) begin
                    sum = 0;
                    foreach (un_pad[i]) sum += un_pad[i];
                    if (sum > mask + 1) sum = mask + 1;
                    for (int k = 0; k < sum; k++) resmap[(un_start[0] + k) & mask] = 1;
                end
                un_start.delete(); un_pad.delete();
                m_cnt = 0;
            end else if (ev_rd && m_flag) begin
                foreach (resmap[i]) resmap[i] = 0;
            end
            if (done) begin
                m_cnt++;
                m_sof = m_base;
                m_wp = (m_base + m_pad) & mask;
                un_start.push_back(m_base); un_pad.push_back(m_pad);
            end
            if (m_cnt == 0) m_flag = 0;
            else if (m_stream ? stream_end : done) m_flag = 1;
            if (start) begin
                m_busy = 1; m_base = m_wp; m_pad = pad; m_idx = 0;
                m_words = (int'(frm_len) + 1) / 2;
            end else if (accept) begin
                if (done) m_busy = 0; else m_idx++;
            end
        end
        if (hst_wr && hst_addr == 2'd3) begin
            m_big = hst_wdata[0]; m_irqen = hst_wdata[1]; m_stream = hst_wdata[2];
        end
        m_rstp = new_rstp;
        if (drop || done) begin
            void'(q_len.pop_front()); void'(q_good.pop_front()); void'(q_id.pop_front());
        end
        @(negedge clk);
        refresh_src();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int data);
        hst_addr = 2'd3; hst_wr = 1'b1; hst_wdata = 16'(data);
        step();
        hst_wr = 1'b0;
    endtask

    task automatic rd(int a);
        hst_addr = 2'(a); hst_rd = 1'b1;
        step();
        hst_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt0;
        model_clear();
        m_big = 0; m_irqen = 0; m_stream = 0; m_rstp = 0; m_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state of every register (R4, R5, R8, R11)
        for (int a = 0; a < 4; a++) begin hst_addr = 2'(a); step(); end
        // Three good frames, interrupt enabled (R3, R4, R10)
        wr(16'h0002);
        push(5, 1); push(8, 1); push(3, 1);
        hst_addr = 2'd1; run(30);
        chk("R4 offset after three", int'(hst_rdata), 16);
        // Rejected frame is dropped (R1)
        hst_addr = 2'd0; cnt0 = m_cnt;
        push(7, 0); run(5);
        chk("R1 queue drained", q_len.size(), 0);
        chk("R1 count unchanged", int'(hst_rdata), cnt0);
        // Count read reserves bytes 0..19, ring wraps into them (R5, R6)
        rd(0);
        slow = 1;
        push(20, 1); push(20, 1); push(12, 1);
        run(60);
        chk("R6 frame held", q_len.size(), 1);
        chk("R6 no write", int'(dma_valid), 0);
        // Implied skip releases it (R7, R8)
        hst_addr = 2'd2; step();
        chk("R8 flag set", int'(hst_rdata[7]), 1);
        rd(2);
        chk("R8 flag kept after read", int'(hst_rdata[7]), 1);
        run(30);
        chk("R7 released frame moved", q_len.size(), 0);
        // Reread reserves the newest frames; a second reread releases (R7)
        rd(0); push(30, 1); run(40);
        chk("R6 held by reread", q_len.size(), 1);
        rd(0); run(40);
        chk("R7 reread releases", q_len.size(), 0);
        // Stream mode flag (R9)
        wr(16'h0004); rd(0);
        push(6, 1); hst_addr = 2'd2; run(15);
        chk("R9 flag waits for stream end", int'(hst_rdata[7]), 0);
        stream_end = 1'b1; step(); stream_end = 1'b0; step();
        chk("R9 flag after stream end", int'(hst_rdata[7]), 1);
        // Reset in the middle of a frame (R11)
        wr(16'h0002); rd(0);
        push(30, 1); run(6);
        wr(16'h0042);
        step();
        hst_addr = 2'd1; run(40);
        chk("R11 restart at base", int'(hst_rdata), 0);
        // Large buffer, overwrite without reservation, wrap (R2)
        wr(16'h0041); step();
        for (int i = 0; i < 8; i++) push(18, 1);
        hst_addr = 2'd1; run(150);
        chk("R2 large wrap offset", int'(hst_rdata), 12);
        hst_addr = 2'd0; step();
        chk("R5 count of eight", int'(hst_rdata), 8);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule